// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This unit sits beside a first-level cache and handles the cache's block misses. Each miss is checked against a small set of stream slots before memory is involved. A slot holds one block address, its data, and two flags: one marks the slot valid, and one marks it pending while its fetch is still in flight. When a slot holds the missed block, the block goes straight back to the cache with no demand fetch. The slot then moves on to the next sequential block, so the stream stays one block ahead. When no slot matches, the unit fetches the missed block on demand. It also gives the least recently used slot the next block after the miss and prefetches it.

Prefetched blocks stay inside the slots and never enter the cache unless a later miss asks for them, so a wrong guess cannot displace useful lines. The slot count is a parameter, and 1, 4 and 8 slots are sensible choices. The unit does not care whether the misses come from instruction or data fetches. It serves one miss at a time. The memory port carries block addresses, and every response echoes the address it answers.

Top module: `stream_prefetch`

## Requirements
- R1: After reset `miss_ready` is 1, `ret_valid` is 0 and `mem_req_valid` is 0, and every slot is empty.
- R2: A miss accepted (`miss_valid` and `miss_ready` high at a clock edge) that matches no valid slot raises `mem_req_valid` with `mem_req_addr` equal to the missed address in the next cycle. The block is returned on `ret_*` in the cycle after a response for that address arrives.
- R3: On such a miss, the least recently used slot is reloaded with the missed address plus one, marked pending, and its prefetch request follows the demand request.
- R4: An accepted miss that matches a valid, non-pending slot is returned in the next cycle with that slot's data, and no demand request is made for it.
- R5: After every hit the slot moves to the hit address plus one and requests that block. A scan of N consecutive blocks after reset therefore makes exactly N+1 memory requests.
- R6: An accepted miss that matches a pending slot holds `miss_ready` low and waits. The block is returned one cycle after the slot's data has been filled.
- R7: Slot recency is updated on every accepted miss. After reset the slot with the highest index is the least recently used.
- R8: A pending demand request always takes the memory port ahead of prefetches. Among the slots waiting to prefetch, the lowest index goes first.
- R9: A memory response fills every pending slot whose block address equals the response address and clears that slot's pending flag.
- R10: `miss_ready` is low from the acceptance of a miss that cannot be returned at once until its return. Whenever `ret_valid` is 1, `miss_ready` is also 1.
- R11: `ret_data` always equals the memory contents of the block at `ret_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Cache presents a missed block address |
| miss_addr | input | AB | Missed block address |
| miss_ready | output | 1 | Unit can accept a miss |
| ret_valid | output | 1 | Block returned to the cache this cycle |
| ret_addr | output | AB | Address of the returned block |
| ret_data | output | DB | Returned block data |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | AB | Requested block address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_resp_valid | input | 1 | Memory response present |
| mem_resp_addr | input | AB | Block address answered |
| mem_resp_data | input | DB | Block data answered |

## Verification
A slow sequential scan, with enough idle cycles between misses, produces only hits on slots that are already filled. This separates the hit path and the request count from the waiting path. A back-to-back scan lands on slots that are still pending, which tests the waiting return. Four interleaved streams against four slots should settle into hits only. Five interleaved streams make every miss evict, which exposes the recency order, and random addresses in a narrow window mix all three cases. Memory latency is fixed while the request ready signal drops periodically, so demand priority and held requests are compared cycle by cycle with a behavioural model.

// File: rtl/stream_prefetch.sv
module stream_prefetch #(
  parameter int NS = 4,
  parameter int AB = 16,
  parameter int DB = 32,
  localparam int IW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss_valid,
  input  logic [AB-1:0] miss_addr,
  output logic          miss_ready,
  output logic          ret_valid,
  output logic [AB-1:0] ret_addr,
  output logic [DB-1:0] ret_data,
  output logic          mem_req_valid,
  output logic [AB-1:0] mem_req_addr,
  input  logic          mem_req_ready,
  input  logic          mem_resp_valid,
  input  logic [AB-1:0] mem_resp_addr,
  input  logic [DB-1:0] mem_resp_data
);

  typedef enum logic [1:0] {S_IDLE, S_DEM, S_WAIT} st_t;

  st_t           st_q;
  logic [AB-1:0] cur_q;
  logic          dsent_q;
  logic [IW-1:0] wsel_q;

  logic [AB-1:0] tag_q  [NS];
  logic [DB-1:0] dat_q  [NS];
  logic [IW-1:0] age_q  [NS];
  logic [NS-1:0] val_q, pend_q, need_q, lru_vec;

  logic          hit, pf_any;
  logic [IW-1:0] hsel, vsel, psel;

  always_comb begin
    hit = 1'b0; pf_any = 1'b0;
    hsel = '0; vsel = '0; psel = '0;
    lru_vec = '0;
    for (int i = NS-1; i >= 0; i--) begin
      if (val_q[i] && tag_q[i] == miss_addr) begin hit = 1'b1; hsel = IW'(i); end
      if (need_q[i]) begin pf_any = 1'b1; psel = IW'(i); end
      if (age_q[i] == IW'(NS-1)) begin vsel = IW'(i); lru_vec[i] = 1'b1; end
    end
  end

  wire           accept    = (st_q == S_IDLE) && miss_valid;
  wire           hit_rdy   = hit && !pend_q[hsel];
  wire [IW-1:0]  tsel      = hit ? hsel : vsel;
  wire [IW-1:0]  tage      = age_q[tsel];
  wire [DB-1:0]  hit_dat   = dat_q[hsel];
  wire           dem_req   = (st_q == S_DEM) && !dsent_q;
  wire           wait_done = (st_q == S_WAIT) && !pend_q[wsel_q];
  wire           dem_done  = (st_q == S_DEM) && dsent_q && mem_resp_valid && mem_resp_addr == cur_q;
  wire           pf_gnt    = mem_req_ready && !dem_req && pf_any;
  wire           rt_en     = (accept && !(hit && pend_q[hsel])) || wait_done;
  wire [IW-1:0]  rt_idx    = wait_done ? wsel_q : tsel;
  wire [AB-1:0]  rt_tag    = wait_done ? cur_q + 1'b1 : miss_addr + 1'b1;

  assign miss_ready    = (st_q == S_IDLE);
  assign mem_req_valid = dem_req || pf_any;
  assign mem_req_addr  = dem_req ? cur_q : tag_q[psel];

  for (genvar g = 0; g < NS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val_q[g] <= 1'b0; pend_q[g] <= 1'b0; need_q[g] <= 1'b0;
        tag_q[g] <= '0;   dat_q[g]  <= '0;   age_q[g]  <= IW'(g);
      end else begin
        if (rt_en && rt_idx == IW'(g)) begin
          tag_q[g] <= rt_tag; val_q[g] <= 1'b1; pend_q[g] <= 1'b1; need_q[g] <= 1'b1;
        end else if (mem_resp_valid && pend_q[g] && tag_q[g] == mem_resp_addr) begin
          dat_q[g] <= mem_resp_data; pend_q[g] <= 1'b0; need_q[g] <= 1'b0;
        end else if (pf_gnt && psel == IW'(g)) begin
          need_q[g] <= 1'b0;
        end
        if (accept) begin
          if (tsel == IW'(g)) age_q[g] <= '0;
          else if (age_q[g] < tage) age_q[g] <= age_q[g] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cur_q <= '0; dsent_q <= 1'b0; wsel_q <= '0;
      ret_valid <= 1'b0; ret_addr <= '0; ret_data <= '0;
    end else begin
      ret_valid <= 1'b0;
      case (st_q)
        S_IDLE: if (accept) begin
          cur_q <= miss_addr;
          if (hit_rdy) begin
            ret_valid <= 1'b1; ret_addr <= miss_addr; ret_data <= hit_dat;
          end else if (hit) begin
            st_q <= S_WAIT; wsel_q <= hsel;
          end else begin
            st_q <= S_DEM; dsent_q <= 1'b0;
          end
        end
        S_DEM: begin
          if (dem_req && mem_req_ready) dsent_q <= 1'b1;
          if (dem_done) begin
            ret_valid <= 1'b1; ret_addr <= cur_q; ret_data <= mem_resp_data; st_q <= S_IDLE;
          end
        end
        S_WAIT: if (wait_done) begin
          ret_valid <= 1'b1; ret_addr <= cur_q; ret_data <= dat_q[wsel_q]; st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_LRU_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) $countones(lru_vec) == 1); // R7
  AST_MISS_DEMAND_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !hit |=> mem_req_valid && mem_req_addr == $past(miss_addr)); // R2
  AST_HIT_RETURN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit_rdy |=> ret_valid && ret_addr == $past(miss_addr) && ret_data == $past(hit_dat)); // R4
  AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit && !hit_rdy |=> !miss_ready && !ret_valid); // R6
  AST_RET_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n) ret_valid |-> miss_ready); // R10

endmodule

// File: tb/stream_prefetch_tb.sv
module stream_prefetch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4, AB = 16, DB = 32, LAT = 6;

  logic clk = 0, rst_n = 0;
  logic miss_valid = 0, mem_req_ready = 0, mem_resp_valid = 0;
  logic [AB-1:0] miss_addr = '0, mem_resp_addr = '0;
  logic [DB-1:0] mem_resp_data = '0;
  logic miss_ready, ret_valid, mem_req_valid;
  logic [AB-1:0] ret_addr, mem_req_addr;
  logic [DB-1:0] ret_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_prefetch #(.NS(NS), .AB(AB), .DB(DB)) u_dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
    .ret_valid(ret_valid), .ret_addr(ret_addr), .ret_data(ret_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .mem_resp_valid(mem_resp_valid), .mem_resp_addr(mem_resp_addr), .mem_resp_data(mem_resp_data));

  int total = 0, bad = 0, cyc = 0, reqcnt = 0, retcnt = 0;

  function automatic logic [DB-1:0] mdat(logic [AB-1:0] a);
    return {a ^ 16'h5a5a, a};
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc); end
  endtask

  // behavioural reference
  int m_st, m_wsel; bit m_dsent; logic [AB-1:0] m_cur;
  logic [AB-1:0] m_tag[NS]; logic [DB-1:0] m_dat[NS];
  bit m_val[NS], m_pend[NS], m_need[NS];
  int lru[$];
  bit m_rv; logic [AB-1:0] m_ra; logic [DB-1:0] m_rd;

  task automatic model_reset();
    m_st = 0; m_wsel = 0; m_dsent = 0; m_cur = '0; m_rv = 0; m_ra = '0; m_rd = '0;
    lru.delete();
    for (int i = 0; i < NS; i++) begin
      m_val[i] = 0; m_pend[i] = 0; m_need[i] = 0; m_tag[i] = '0; m_dat[i] = '0; lru.push_back(i);
    end
  endtask

  function automatic int first_need();
    for (int i = 0; i < NS; i++) if (m_need[i]) return i;
    return -1;
  endfunction

  function automatic bit exp_req_v();
    return (m_st == 1 && !m_dsent) || first_need() >= 0;
  endfunction

  function automatic logic [AB-1:0] exp_req_a();
    if (m_st == 1 && !m_dsent) return m_cur;
    if (first_need() >= 0) return m_tag[first_need()];
    return '0;
  endfunction

  task automatic retarget(int s, logic [AB-1:0] t);
    m_tag[s] = t; m_val[s] = 1; m_pend[s] = 1; m_need[s] = 1;
  endtask

  task automatic model_step(bit mv, logic [AB-1:0] ma, bit rdy, bit rv, logic [AB-1:0] ra, logic [DB-1:0] rd);
    int hit = -1, pf = first_need(), tsel, idx;
    bit dreq = (m_st == 1 && !m_dsent);
    bit wdone = (m_st == 2 && !m_pend[m_wsel]);
    for (int i = NS-1; i >= 0; i--) if (m_val[i] && m_tag[i] == ma) hit = i;
    m_rv = 0;
    if (rdy && !dreq && pf >= 0) m_need[pf] = 0;
    if (m_st == 1 && m_dsent && rv && ra == m_cur) begin m_rv = 1; m_ra = m_cur; m_rd = rd; m_st = 0; end
    if (wdone) begin m_rv = 1; m_ra = m_cur; m_rd = m_dat[m_wsel]; m_st = 0; end
    for (int i = 0; i < NS; i++)
      if (rv && m_pend[i] && m_tag[i] == ra && !(wdone && i == m_wsel)) begin
        m_dat[i] = rd; m_pend[i] = 0; m_need[i] = 0;
      end
    if (wdone) retarget(m_wsel, m_cur + 1'b1);
    if (dreq && rdy) m_dsent = 1;
    if (m_st == 0 && mv && !(m_rv && !wdone && m_ra == m_cur && m_st == 0 && 0)) begin
      if (!m_rv || wdone || 1) ;
    end
  endtask

  // accept handled separately so that it sees the pre-edge state
  task automatic model_accept(bit acc, logic [AB-1:0] ma, int hit, bit hit_pend);
    int tsel;
    if (!acc) return;
    m_cur = ma;
    tsel = (hit >= 0) ? hit : lru[$];
    for (int i = 0; i < lru.size(); i++) if (lru[i] == tsel) begin lru.delete(i); break; end
    lru.push_front(tsel);
    if (hit >= 0 && !hit_pend) begin
      m_rv = 1; m_ra = ma; m_rd = m_dat[hit]; retarget(hit, ma + 1'b1);
    end else if (hit >= 0) begin
      m_st = 2; m_wsel = hit;
    end else begin
      m_st = 1; m_dsent = 0; retarget(tsel, ma + 1'b1);
    end
  endtask

  // stimulus state
  int todo_a[$], todo_g[$];
  bit cur_v = 0; int gap_left = 0;
  int mq_a[$], mq_due[$];
  bit s_mv, s_rdy, s_rv, s_reqv; logic [AB-1:0] s_ma, s_ra, s_reqa; logic [DB-1:0] s_rd;

  task automatic step();
    int hit; bit hp, acc;
    @(negedge clk);
    cyc++;
    chk(miss_ready === (m_st == 0), "R10", miss_ready, m_st == 0);
    chk(ret_valid === m_rv, "R2/R4/R6", ret_valid, m_rv);
    if (m_rv) begin
      chk(ret_addr === m_ra, "R2/R4/R6", ret_addr, m_ra);
      chk(ret_data === m_rd, "R9", ret_data, m_rd);
      chk(ret_data === mdat(ret_addr), "R11", ret_data, mdat(ret_addr));
      retcnt++;
    end
    chk(mem_req_valid === exp_req_v(), "R8", mem_req_valid, exp_req_v());
    if (exp_req_v()) chk(mem_req_addr === exp_req_a(), "R3/R5/R7/R8", mem_req_addr, exp_req_a());
    if (!cur_v && todo_a.size() > 0) begin
      if (gap_left > 0) gap_left--;
      else begin
        cur_v = 1; miss_addr = AB'(todo_a.pop_front()); gap_left = todo_g.pop_front();
      end
    end
    miss_valid = cur_v;
    mem_req_ready = (cyc % 7) != 3;
    if (mq_a.size() > 0 && mq_due[0] <= cyc) begin
      mem_resp_valid = 1; mem_resp_addr = AB'(mq_a[0]); mem_resp_data = mdat(AB'(mq_a[0]));
    end else mem_resp_valid = 0;
    s_mv = miss_valid; s_ma = miss_addr; s_rdy = mem_req_ready; s_rv = mem_resp_valid;
    s_ra = mem_resp_addr; s_rd = mem_resp_data; s_reqv = mem_req_valid; s_reqa = mem_req_addr;
    hit = -1;
    for (int i = NS-1; i >= 0; i--) if (m_val[i] && m_tag[i] == s_ma) hit = i;
    hp = (hit >= 0) ? m_pend[hit] : 0;
    acc = s_mv && (m_st == 0);
    @(posedge clk); #1;
    if (s_reqv && s_rdy) begin mq_a.push_back(int'(s_reqa)); mq_due.push_back(cyc + LAT); reqcnt++; end
    if (s_rv) begin void'(mq_a.pop_front()); void'(mq_due.pop_front()); end
    model_step(acc, s_ma, s_rdy, s_rv, s_ra, s_rd);
    model_accept(acc, s_ma, hit, hp);
    if (acc) cur_v = 0;
  endtask

  function automatic bit busy();
    return todo_a.size() > 0 || cur_v || m_st != 0 || m_rv || mq_a.size() > 0 || first_need() >= 0;
  endfunction

  task automatic drain();
    int n = 0;
    step();
    while (busy() && n < 5000) begin step(); n++; end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog timeout R2 actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lf = 16'hace1;
    model_reset();
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(miss_ready === 1'b1, "R1", miss_ready, 1);
    chk(ret_valid === 1'b0, "R1", ret_valid, 0);
    chk(mem_req_valid === 1'b0, "R1", mem_req_valid, 0);

    // slow scan: hits find filled slots (R4, R5)
    reqcnt = 0; retcnt = 0;
    for (int k = 0; k < 16; k++) begin todo_a.push_back(16'h100 + k); todo_g.push_back(12); end
    drain();
    chk(reqcnt == 17, "R5", reqcnt, 17);
    chk(retcnt == 16, "R4", retcnt, 16);

    // back-to-back scan: hits on pending slots (R6)
    for (int k = 0; k < 12; k++) begin todo_a.push_back(16'h300 + k); todo_g.push_back(0); end
    drain();

    // four interleaved streams (R7)
    for (int r = 0; r < 8; r++)
      for (int s = 0; s < 4; s++) begin todo_a.push_back(16'h1000 * (s + 2) + r); todo_g.push_back(1); end
    drain();

    // five interleaved streams thrash the slots (R3, R7)
    for (int r = 0; r < 6; r++)
      for (int s = 0; s < 5; s++) begin todo_a.push_back(16'h0800 * (s + 1) + 16'h40 + r); todo_g.push_back(0); end
    drain();

    // random narrow window (R2, R8, R9)
    for (int k = 0; k < 60; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      todo_a.push_back(16'h500 + (lf % 24)); todo_g.push_back(lf[1:0]);
    end
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule